// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models the status-reporting side of a byte-wide NOR flash that is split into equal sectors. It does not hold array contents. An external array supplies them: `arr_raddr` follows the read address, and `arr_rdata` returns the stored byte. When a byte program or an erase finishes, the block tells the array what to change through one-cycle strobes. Commands arrive as single-cycle pulses that have already been decoded: start program, start sector erase, start chip erase, suspend, resume and reset.

A read strobe returns either array data or an 8-bit status word. Which one depends on the operation in progress and on the sector being read. While an operation runs, the status word has a bit that flips on every read, a bit that flips only for sectors queued for erase, and a timeout flag. Program or erase requests that reach only protected sectors keep the status busy for a bounded number of cycles and then change nothing. A program that would have to raise a 0 to a 1 stalls until a pulse limit is reached. The block then stays in a failed state until it receives a reset command.

Top module: `flash_op_status`

## Requirements
- R1: While `rst_n` is low, `rd_data` is 0 and neither `arr_we` nor `ers_we` is high. With no operation pending, a read strobe returns `arr_rdata` for the strobed address on `rd_data` in the cycle after the strobe. This also applies after a reset applied in the middle of an operation.
- R2: The sector index is the top `$clog2(NSEC)` address bits (bits 18:16 at default sizes). It alone selects protection, erase-set membership and suspend routing.
- R3: Bit 6 of the status word inverts on every status read while a program or erase is running, and also while the block is in the failed state. In every other case it holds.
- R4: A program to an unprotected sector that needs no 0-to-1 change is busy for exactly `PROG_CYC` cycles after the command edge. It then pulses `arr_we` for one cycle with the latched address and data, and reads return array data again.
- R5: A program to a protected sector is busy for `PROT_PROG_CYC` cycles and then returns to array reads without any `arr_we` pulse.
- R6: An erase covers the selected sectors (`erase_sel`, or all sectors for a chip erase) minus the protected ones. After `ERASE_CYC` cycles it pulses `ers_we` with that mask on `ers_mask`. If every selected sector is protected, the erase is busy for `PROT_ERASE_CYC` cycles and produces no `ers_we`.
- R7: A program whose data has a 1 where `prog_old` has a 0 stays busy for `PULSE_LIMIT` cycles. It then sets status bit 5 and keeps returning status on every read until `cmd_reset`. After that, array reads resume.
- R8: Status bit 2 inverts on a status read whose sector is in the pending erase set. On any other status read it repeats its last value.
- R9: During erase suspend, reads in pending-erase sectors return status with bit 7 = 1 and bit 6 held, while bit 2 still toggles. Reads in other sectors return array data. After resume, the erase runs only its remaining cycles.
- R10: During erase suspend, a program to a sector outside the erase set runs as in R4 and then returns to suspend. A program into a suspended sector is ignored.
- R11: The status word is {b7, toggle6, timeout5, 0, 0, toggle2, 0, 0}. b7 is the complement of the programmed bit 7 during a program or a failure, 0 during an active erase, and 1 in suspend.
- R12: While a program is running, erase and reset commands have no effect on its length or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Registered read word (array data or status) |
| arr_raddr | output | ADDR_W | Address presented to the external array |
| arr_rdata | input | 8 | Array byte at `arr_raddr` |
| cmd_prog | input | 1 | Start byte program |
| prog_addr | input | ADDR_W | Program target address |
| prog_data | input | 8 | Byte to program |
| prog_old | input | 8 | Byte currently stored at `prog_addr` |
| cmd_erase | input | 1 | Start erase of `erase_sel` |
| erase_sel | input | NSEC | One bit per sector to erase |
| cmd_chip_erase | input | 1 | Start erase of every sector |
| cmd_suspend | input | 1 | Suspend a running erase |
| cmd_resume | input | 1 | Resume a suspended erase |
| cmd_reset | input | 1 | Leave the failed state |
| prot_mask | input | NSEC | One bit per protected sector |
| arr_we | output | 1 | One-cycle program commit |
| arr_waddr | output | ADDR_W | Program commit address |
| arr_wdata | output | 8 | Program commit data |
| ers_we | output | 1 | One-cycle erase commit |
| ers_mask | output | NSEC | Sectors erased by the commit |

## Verification
The bench builds the block with `PROG_CYC`=6, `ERASE_CYC`=20, `PROT_PROG_CYC`=3, `PROT_ERASE_CYC`=9 and `PULSE_LIMIT`=11, and protects sectors 1 and 6. Each of these lengths is distinct, so a read sequence ending one cycle early or late exposes a wrong duration. It also shows a swap between normal, protected and stalled timing. A 20-cycle erase leaves room to suspend after three cycles, run a full program inside the suspend, and then count exactly 17 remaining busy reads after resume. The stall limit is short enough to reach the failed state and recover from it within each pass through the program vector table.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_ERASE, ST_ESUSP, ST_SPROG, ST_FAIL
  } op_state_e;

  typedef enum logic [1:0] {PG_OK, PG_PROT, PG_STALL, PG_SKIP} prog_class_e;

  typedef enum logic [1:0] {EC_NONE, EC_PROT, EC_RUN} ers_class_e;

  // bits to raise from 0 to 1 cannot be programmed
  function automatic logic needs_raise(logic [7:0] old_b, logic [7:0] new_b);
    return |(new_b & ~old_b);
  endfunction

  function automatic logic [7:0] status_word(logic b7, logic b6, logic b5, logic b2);
    return {b7, b6, b5, 2'b00, b2, 2'b00};
  endfunction

  function automatic logic is_active(op_state_e s);
    return (s == ST_PROG) || (s == ST_ERASE) || (s == ST_SPROG) || (s == ST_FAIL);
  endfunction

  function automatic int cnt_width(int a, int b, int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/fs_guard.sv
module fs_guard import flash_stat_pkg::*; #(
  parameter int NSEC = 8,
  localparam int SEC_W = $clog2(NSEC)
) (
  input  logic [SEC_W-1:0] prog_sec,
  input  logic [7:0]       prog_data,
  input  logic [7:0]       prog_old,
  input  logic [NSEC-1:0]  prot_mask,
  input  logic [NSEC-1:0]  ers_set,
  input  logic             in_susp,
  input  logic [NSEC-1:0]  ers_req,
  output prog_class_e      prog_class,
  output ers_class_e       ers_class,
  output logic [NSEC-1:0]  ers_eff
);

  logic sec_suspended;
  logic sec_locked;
  logic raise_needed;

  assign sec_suspended = in_susp && ers_set[prog_sec];
  assign sec_locked    = prot_mask[prog_sec];
  assign raise_needed  = needs_raise(prog_old, prog_data);

  always_comb begin
    if (sec_suspended)     prog_class = PG_SKIP;
    else if (sec_locked)   prog_class = PG_PROT;
    else if (raise_needed) prog_class = PG_STALL;
    else                   prog_class = PG_OK;
  end

  assign ers_eff = ers_req & ~prot_mask;

  always_comb begin
    if (ers_req == '0)      ers_class = EC_NONE;
    else if (ers_eff == '0) ers_class = EC_PROT;
    else                    ers_class = EC_RUN;
  end

endmodule

// File: rtl/fs_seq.sv
module fs_seq import flash_stat_pkg::*; #(
  parameter int ADDR_W         = 19,
  parameter int NSEC           = 8,
  parameter int PROG_CYC       = 1000,
  parameter int ERASE_CYC      = 50_000_000,
  parameter int PROT_PROG_CYC  = 200,
  parameter int PROT_ERASE_CYC = 10_000,
  parameter int PULSE_LIMIT    = 4000,
  localparam int PW = cnt_width(PROG_CYC, PROT_PROG_CYC, PULSE_LIMIT),
  localparam int EW = cnt_width(ERASE_CYC, PROT_ERASE_CYC, 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_prog,
  input  logic              erase_go,
  input  logic              cmd_suspend,
  input  logic              cmd_resume,
  input  logic              cmd_reset,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  prog_class_e       prog_class,
  input  ers_class_e        ers_class,
  input  logic [NSEC-1:0]   ers_req,
  input  logic [NSEC-1:0]   ers_eff,
  output op_state_e         state,
  output logic [NSEC-1:0]   ers_set,
  output logic              pdata7,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [7:0]        arr_wdata,
  output logic              ers_we,
  output logic [NSEC-1:0]   ers_mask
);

  logic [PW-1:0]   pcnt, plast;
  logic [EW-1:0]   ecnt, elast;
  prog_class_e     pkind;
  logic            erun;
  logic [NSEC-1:0] ers_eff_q;

  // named internal events
  logic prog_start, erase_start, prog_end, erase_end;

  assign prog_start  = cmd_prog && (prog_class != PG_SKIP) &&
                       ((state == ST_IDLE) || (state == ST_ESUSP));
  assign erase_start = erase_go && !prog_start && (ers_class != EC_NONE) &&
                       (state == ST_IDLE);
  assign prog_end    = ((state == ST_PROG) || (state == ST_SPROG)) && (pcnt == plast);
  assign erase_end   = (state == ST_ERASE) && !cmd_suspend && (ecnt == elast);
  assign pdata7      = arr_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pcnt      <= '0;
      plast     <= '0;
      ecnt      <= '0;
      elast     <= '0;
      pkind     <= PG_OK;
      erun      <= 1'b0;
      ers_eff_q <= '0;
      ers_set   <= '0;
      arr_we    <= 1'b0;
      arr_waddr <= '0;
      arr_wdata <= '0;
      ers_we    <= 1'b0;
      ers_mask  <= '0;
    end else begin
      arr_we <= 1'b0;
      ers_we <= 1'b0;
      if (prog_start) begin
        state     <= (state == ST_ESUSP) ? ST_SPROG : ST_PROG;
        pcnt      <= '0;
        pkind     <= prog_class;
        arr_waddr <= prog_addr;
        arr_wdata <= prog_data;
        plast     <= (prog_class == PG_OK)   ? PW'(PROG_CYC - 1) :
                     (prog_class == PG_PROT) ? PW'(PROT_PROG_CYC - 1) :
                                               PW'(PULSE_LIMIT - 1);
      end else if (erase_start) begin
        state     <= ST_ERASE;
        ecnt      <= '0;
        erun      <= (ers_class == EC_RUN);
        ers_set   <= ers_req;
        ers_eff_q <= ers_eff;
        elast     <= (ers_class == EC_RUN) ? EW'(ERASE_CYC - 1) : EW'(PROT_ERASE_CYC - 1);
      end else begin
        case (state)
          ST_PROG, ST_SPROG: begin
            if (prog_end) begin
              if (pkind == PG_STALL) begin
                state <= ST_FAIL;
              end else begin
                arr_we <= (pkind == PG_OK);
                state  <= (state == ST_SPROG) ? ST_ESUSP : ST_IDLE;
              end
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
          ST_ERASE: begin
            if (cmd_suspend) begin
              state <= ST_ESUSP;
            end else if (erase_end) begin
              state    <= ST_IDLE;
              ers_we   <= erun;
              ers_mask <= ers_eff_q;
              ers_set  <= '0;
            end else begin
              ecnt <= ecnt + 1'b1;
            end
          end
          ST_ESUSP: if (cmd_resume) state <= ST_ERASE;
          ST_FAIL: begin
            if (cmd_reset) begin
              state   <= ST_IDLE;
              ers_set <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAIL) && !cmd_reset |=> (state == ST_FAIL)); // R7
  AST_FAIL_FROM_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAIL) && ($past(state) != ST_FAIL) |-> ($past(pkind) == PG_STALL)); // R7
  AST_WE_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (($past(state) == ST_PROG) || ($past(state) == ST_SPROG))); // R4
  AST_ERS_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    ers_we |-> ($past(state) == ST_ERASE)); // R6
  AST_ERS_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    ers_we |-> ((ers_mask & ~$past(ers_set)) == '0)); // R6
  AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PROG) || (state == ST_SPROG)) |-> (pcnt <= plast)); // R4
  AST_SUSP_HOLDS_ECNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ESUSP) |=> $stable(ecnt)); // R9

endmodule

// File: rtl/fs_status.sv
module fs_status import flash_stat_pkg::*; #(
  parameter int NSEC = 8,
  localparam int SEC_W = $clog2(NSEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [SEC_W-1:0] rd_sec,
  input  logic [7:0]       arr_rdata,
  input  op_state_e        state,
  input  logic [NSEC-1:0]  ers_set,
  input  logic             pdata7,
  output logic [7:0]       rd_data
);

  logic t6, t2;
  logic in_set, act, susp, show_stat, flip6, flip2, b7;

  assign in_set    = ers_set[rd_sec];
  assign act       = is_active(state);
  assign susp      = (state == ST_ESUSP);
  assign show_stat = act || (susp && in_set);
  assign flip6     = rd_en && act;
  assign flip2     = rd_en && show_stat && in_set;
  assign b7        = susp ? 1'b1 : (state == ST_ERASE) ? 1'b0 : ~pdata7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6      <= 1'b0;
      t2      <= 1'b0;
      rd_data <= '0;
    end else begin
      t6 <= t6 ^ flip6;
      t2 <= t2 ^ flip2;
      if (rd_en)
        rd_data <= show_stat ? status_word(b7, t6 ^ flip6, state == ST_FAIL, t2 ^ flip2)
                             : arr_rdata;
    end
  end

  AST_SUSP_B6_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    susp |=> $stable(t6)); // R9
  AST_IDLE_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (state == ST_IDLE) |=> (rd_data == $past(arr_rdata))); // R1
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && act |=> (rd_data[4:3] == 2'b00) && (rd_data[1:0] == 2'b00)); // R11
  AST_B6_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && act |=> (rd_data[6] != $past(t6))); // R3

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status import flash_stat_pkg::*; #(
  parameter int ADDR_W         = 19,
  parameter int NSEC           = 8,
  parameter int PROG_CYC       = 1000,
  parameter int ERASE_CYC      = 50_000_000,
  parameter int PROT_PROG_CYC  = 200,
  parameter int PROT_ERASE_CYC = 10_000,
  parameter int PULSE_LIMIT    = 4000,
  localparam int SEC_W = $clog2(NSEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [7:0]        arr_rdata,
  input  logic              cmd_prog,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic [7:0]        prog_old,
  input  logic              cmd_erase,
  input  logic [NSEC-1:0]   erase_sel,
  input  logic              cmd_chip_erase,
  input  logic              cmd_suspend,
  input  logic              cmd_resume,
  input  logic              cmd_reset,
  input  logic [NSEC-1:0]   prot_mask,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [7:0]        arr_wdata,
  output logic              ers_we,
  output logic [NSEC-1:0]   ers_mask
);

  op_state_e       state;
  prog_class_e     prog_class;
  ers_class_e      ers_class;
  logic [NSEC-1:0] ers_set, ers_req, ers_eff;
  logic [SEC_W-1:0] prog_sec, rd_sec;
  logic            erase_go, pdata7;

  assign arr_raddr = rd_addr;
  assign rd_sec    = rd_addr[ADDR_W-1 -: SEC_W];
  assign prog_sec  = prog_addr[ADDR_W-1 -: SEC_W];
  assign erase_go  = cmd_erase || cmd_chip_erase;
  assign ers_req   = cmd_chip_erase ? {NSEC{1'b1}} : erase_sel;

  fs_guard #(.NSEC(NSEC)) u_guard (
    .prog_sec   (prog_sec),
    .prog_data  (prog_data),
    .prog_old   (prog_old),
    .prot_mask  (prot_mask),
    .ers_set    (ers_set),
    .in_susp    (state == ST_ESUSP),
    .ers_req    (ers_req),
    .prog_class (prog_class),
    .ers_class  (ers_class),
    .ers_eff    (ers_eff)
  );

  fs_seq #(
    .ADDR_W(ADDR_W), .NSEC(NSEC), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .PROT_PROG_CYC(PROT_PROG_CYC), .PROT_ERASE_CYC(PROT_ERASE_CYC),
    .PULSE_LIMIT(PULSE_LIMIT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_prog    (cmd_prog),
    .erase_go    (erase_go),
    .cmd_suspend (cmd_suspend),
    .cmd_resume  (cmd_resume),
    .cmd_reset   (cmd_reset),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data),
    .prog_class  (prog_class),
    .ers_class   (ers_class),
    .ers_req     (ers_req),
    .ers_eff     (ers_eff),
    .state       (state),
    .ers_set     (ers_set),
    .pdata7      (pdata7),
    .arr_we      (arr_we),
    .arr_waddr   (arr_waddr),
    .arr_wdata   (arr_wdata),
    .ers_we      (ers_we),
    .ers_mask    (ers_mask)
  );

  fs_status #(.NSEC(NSEC)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_sec    (rd_sec),
    .arr_rdata (arr_rdata),
    .state     (state),
    .ers_set   (ers_set),
    .pdata7    (pdata7),
    .rd_data   (rd_data)
  );

  AST_WE_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !prot_mask[arr_waddr[ADDR_W-1 -: SEC_W]]); // R5
  AST_ERS_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
    ers_we |-> ((ers_mask & prot_mask) == '0)); // R6

endmodule

// File: tb/test_flash_op_status.sv
`timescale 1ns/1ps
module test_flash_op_status;

  localparam int AW = 19;
  localparam int PC = 6, EC = 20, PPC = 3, PEC = 9, LIM = 11;
  localparam logic [7:0] PROT = 8'h42;

  // {address, data, old byte, kind}: kind 0 ok, 1 protected, 2 stall
  localparam logic [36:0] PVEC [0:6] = '{
    {19'h0FFFF, 8'h3C, 8'hFF, 2'd0},
    {19'h10000, 8'h3C, 8'hFF, 2'd1},
    {19'h6ABCD, 8'h00, 8'hFF, 2'd1},
    {19'h70000, 8'h81, 8'h8F, 2'd0},
    {19'h21234, 8'h0F, 8'h0E, 2'd2},
    {19'h5FFFF, 8'h80, 8'h7F, 2'd2},
    {19'h7FFFF, 8'h00, 8'h00, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0, arr_raddr, prog_addr = '0, arr_waddr;
  logic [7:0] rd_data, arr_rdata, prog_data = '0, prog_old = '0, arr_wdata;
  logic cmd_prog = 0, cmd_erase = 0, cmd_chip_erase = 0, cmd_suspend = 0, cmd_resume = 0, cmd_reset = 0;
  logic [7:0] erase_sel = '0, ers_mask;
  logic arr_we, ers_we;

  int checks = 0, errors = 0, n_we = 0, n_ers = 0;
  logic [AW-1:0] last_wa;
  logic [7:0] last_wd, last_em, got;
  logic m6 = 1'b0, m2 = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] amodel(logic [AW-1:0] a);
    return a[7:0] ^ {a[18:16], 5'b10101};
  endfunction
  assign arr_rdata = amodel(arr_raddr);

  flash_op_status #(.PROG_CYC(PC), .ERASE_CYC(EC), .PROT_PROG_CYC(PPC),
                    .PROT_ERASE_CYC(PEC), .PULSE_LIMIT(LIM)) i_flash_op_status (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata), .cmd_prog(cmd_prog),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_old(prog_old),
    .cmd_erase(cmd_erase), .erase_sel(erase_sel), .cmd_chip_erase(cmd_chip_erase),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
    .prot_mask(PROT), .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .ers_we(ers_we), .ers_mask(ers_mask));

  always @(posedge clk) begin
    if (arr_we) begin n_we <= n_we + 1; last_wa <= arr_waddr; last_wd <= arr_wdata; end
    if (ers_we) begin n_ers <= n_ers + 1; last_em <= ers_mask; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    got = rd_data;
  endtask

  // status read: f6/f2 say whether the model's toggle bits invert
  task automatic sread(input logic [AW-1:0] a, input logic b7, input logic b5,
                       input logic f6, input logic f2, input string req);
    rd(a);
    if (f6) m6 = ~m6;
    if (f2) m2 = ~m2;
    chk(req, {24'h0, got}, {24'h0, b7, m6, b5, 2'b00, m2, 2'b00});
  endtask

  task automatic aread(input logic [AW-1:0] a, input string req);
    rd(a);
    chk(req, {24'h0, got}, {24'h0, amodel(a)});
  endtask

  task automatic issue(input int w);
    case (w)
      0: cmd_prog = 1'b1;
      1: cmd_erase = 1'b1;
      2: cmd_chip_erase = 1'b1;
      3: cmd_suspend = 1'b1;
      4: cmd_resume = 1'b1;
      default: cmd_reset = 1'b1;
    endcase
    @(negedge clk);
    {cmd_prog, cmd_erase, cmd_chip_erase, cmd_suspend, cmd_resume, cmd_reset} = '0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int we0, er0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", {24'h0, rd_data}, 32'h0);
    chk("R1 no strobes in reset", {30'h0, arr_we, ers_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    aread(19'h00000, "R1");
    aread(19'h7FFFF, "R1 R2");
    aread(19'h3A5C3, "R1");

    // table walk over program cases (R2 R3 R4 R5 R7 R11)
    for (int i = 0; i < 7; i++) begin
      logic [AW-1:0] va; logic [7:0] vd, vo; logic [1:0] vk; int len; string rq;
      {va, vd, vo, vk} = PVEC[i];
      rq  = (vk == 2'd0) ? "R3 R4 R11" : (vk == 2'd1) ? "R2 R3 R5" : "R3 R7 R11";
      len = (vk == 2'd0) ? PC : (vk == 2'd1) ? PPC : LIM;
      prog_addr = va; prog_data = vd; prog_old = vo; we0 = n_we;
      issue(0);
      for (int j = 0; j < len; j++) sread(va, ~vd[7], 1'b0, 1'b1, 1'b0, rq);
      if (vk == 2'd2) begin
        sread(va, ~vd[7], 1'b1, 1'b1, 1'b0, "R7 timeout set");
        sread(va, ~vd[7], 1'b1, 1'b1, 1'b0, "R7 timeout held");
        issue(5);
        aread(va, "R7 after reset cmd");
      end else begin
        aread(va, rq);
      end
      chk(rq, n_we - we0, (vk == 2'd0) ? 1 : 0);
      if (vk == 2'd0) begin
        chk("R4 write addr", {13'h0, last_wa}, {13'h0, va});
        chk("R4 write data", {24'h0, last_wd}, {24'h0, vd});
      end
    end

    // erase with suspend, program in suspend, resume (R6 R8 R9 R10 R11)
    er0 = n_ers;
    erase_sel = 8'h0C;
    issue(1);
    sread(19'h20000, 1'b0, 1'b0, 1'b1, 1'b1, "R8 in set");
    sread(19'h3FFFF, 1'b0, 1'b0, 1'b1, 1'b1, "R8 in set");
    sread(19'h40000, 1'b0, 1'b0, 1'b1, 1'b0, "R8 outside set holds");
    issue(3);
    sread(19'h21000, 1'b1, 1'b0, 1'b0, 1'b1, "R9 suspended status");
    aread(19'h40010, "R9 other sector array");
    prog_addr = 19'h40010; prog_data = 8'h3C; prog_old = 8'hFF; we0 = n_we;
    issue(0);
    for (int j = 0; j < PC; j++) sread(19'h40010, 1'b1, 1'b0, 1'b1, 1'b0, "R10 prog in suspend");
    aread(19'h40010, "R10 back to suspend");
    chk("R10 commit", n_we - we0, 1);
    sread(19'h30000, 1'b1, 1'b0, 1'b0, 1'b1, "R9 still suspended");
    prog_addr = 19'h30004; prog_data = 8'h00; prog_old = 8'hFF; we0 = n_we;
    issue(0);
    aread(19'h40010, "R10 suspended-sector prog ignored");
    sread(19'h30000, 1'b1, 1'b0, 1'b0, 1'b1, "R10 remains suspended");
    chk("R10 no commit", n_we - we0, 0);
    issue(4);
    for (int j = 0; j < EC - 3; j++) sread(19'h41000, 1'b0, 1'b0, 1'b1, 1'b0, "R9 remaining cycles");
    aread(19'h20000, "R9 R6 erase done");
    chk("R6 erase commit", n_ers - er0, 1);
    chk("R6 erase mask", {24'h0, last_em}, 32'h0C);

    // chip erase minus protected sectors (R6)
    er0 = n_ers;
    issue(2);
    for (int j = 0; j < EC; j++) sread(19'h00100, 1'b0, 1'b0, 1'b1, 1'b1, "R6 chip erase busy");
    aread(19'h00100, "R6 chip erase done");
    chk("R6 chip commit", n_ers - er0, 1);
    chk("R6 chip mask", {24'h0, last_em}, {24'h0, ~PROT});

    // erase of only protected sectors (R6)
    er0 = n_ers;
    erase_sel = PROT;
    issue(1);
    for (int j = 0; j < PEC; j++) sread(19'h10000, 1'b0, 1'b0, 1'b1, 1'b1, "R6 protected erase busy");
    aread(19'h10000, "R6 protected erase done");
    chk("R6 protected erase no commit", n_ers - er0, 0);

    // commands during program ignored (R12)
    prog_addr = 19'h30001; prog_data = 8'h00; prog_old = 8'hFF; we0 = n_we; er0 = n_ers;
    erase_sel = 8'h01;
    issue(0);
    issue(1);
    issue(5);
    for (int j = 0; j < PC - 2; j++) sread(19'h30001, 1'b1, 1'b0, 1'b1, 1'b0, "R12 still busy");
    aread(19'h30001, "R12 ends on time");
    chk("R12 program committed", n_we - we0, 1);
    chk("R12 erase ignored", n_ers - er0, 0);

    // reset in the middle of an erase (R1)
    erase_sel = 8'h01;
    issue(1);
    sread(19'h00000, 1'b0, 1'b0, 1'b1, 1'b1, "R8 before reset");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m6 = 1'b0; m2 = 1'b0;
    @(negedge clk);
    aread(19'h00020, "R1 read after mid-op reset");
    chk("R1 no erase commit after reset", {31'h0, ers_we}, 32'h0);

    done = 1;
    summary();
    $finish;
  end

endmodule